// File: doc/BRIEF.md
# Address-Range Trace Enable Filter

This block decides, for every instruction address presented on its input stream, whether that instruction should be traced. It holds a bank of single-address comparators that are paired into half-open address ranges, a control word that selects which ranges take part and whether they include or exclude code, a start/stop word that turns individual comparators into points that open or close a sticky tracing window, and an event word that gates everything through a small event decoder.

A host programs the registers through a simple write port. A core-side pipe presents an address together with a valid strobe. One cycle later the block raises or lowers a single trace-enable flag. A constant capability output reports how many comparator pairs are built, so software can size its programming loops. Forming trace packets is left to the consumer of the flag.

Top module: `trace_filter`

## Requirements
- R1: After reset the control word is 0x01000000 (exclude polarity, no range selected), the start/stop word and every comparator are 0, the event word is 0x6F, and `trace_en` is 0. With these values every valid address is traced.
- R2: `capability[3:0]` equals NUM_PAIRS, and the block implements twice that many comparators.
- R3: Range k uses comparator 2k as its lower bound and comparator 2k+1 as its upper bound. It matches when lower <= address < upper, so a range whose bounds are equal never matches. Control bit k selects range k.
- R4: With control bit 24 clear (include), the range result is true when any selected range matches, or when no range is selected.
- R5: With control bit 24 set (exclude), the range result is true only when no selected range matches.
- R6: Start/stop word bit n makes comparator n a start point and bit n+16 makes it a stop point, for n below 8. A comparator matches when the address equals its value. On a valid address, a start match sets the sticky state and a stop match clears it. A stop match wins over a start match. The updated state applies to that same address. When control bit 25 is set, the state gates the output.
- R7: The sticky state resets to inactive and changes only on valid addresses. With control bit 25 clear, the state has no effect on the output.
- R8: Event word bits [6:0] hold a code. Code 0x6F is always true, a code below N_EXT selects `ext_evt[code]`, and any other code is false. Bit 14 inverts the result, so 0x406F is never true.
- R9: `trace_en` is registered. It equals valid AND event AND range result (AND sticky state when bit 25 is set) for the address presented on the previous cycle, and it is 0 after a cycle without a valid address.
- R10: A write with `cfg_sel` = i < 2*NUM_PAIRS loads comparator i. Select 2*NUM_PAIRS loads the control word, 2*NUM_PAIRS+1 the start/stop word and 2*NUM_PAIRS+2 the event word (8, 9 and 10 by default). A write is used from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | SEL_W | Register select |
| cfg_wdata | input | 32 | Write data |
| in_valid | input | 1 | Address valid |
| in_addr | input | ADDR_W | Instruction address |
| ext_evt | input | N_EXT | External event inputs |
| trace_en | output | 1 | Registered trace-enable decision |
| capability | output | 4 | Number of comparator pairs |

## Verification
On every cycle the assertions check a set of blocking conditions. An idle cycle, a false event, a selected range hit in exclude mode, or an inactive gated sticky state each force the next flag low. They also check the sticky-state rules: a stop match clears the state, a lone start match sets it, and the state holds without a valid address. Whether the flag is ever correctly high depends on the range arithmetic across overlapping, empty and unselected pairs, and on how the event code is decoded. Only the bench can show these. It sweeps every selection mask in both polarities over an address span that covers all the bounds, and runs start/stop address sequences.

// File: rtl/tef_pkg.sv
package tef_pkg;
    localparam int          CTL_EXCL_BIT  = 24;
    localparam int          CTL_SS_BIT    = 25;
    localparam int          SS_STOP_OFS   = 16;
    localparam int          SS_MAX_CMP    = 8;
    localparam int          EVT_INV_BIT   = 14;
    localparam logic [6:0]  EVT_ALWAYS    = 7'h6F;
    localparam logic [31:0] CTL_RESET     = 32'h0100_0000;
    localparam logic [31:0] EVT_RESET     = 32'h0000_006F;
endpackage

// File: rtl/tef_range_unit.sv
module tef_range_unit #(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] lo,
    input  logic [ADDR_W-1:0] hi,
    output logic              hit
);
    always_comb begin
        hit = (addr >= lo) && (addr < hi);
    end
endmodule

// File: rtl/tef_event_decode.sv
module tef_event_decode #(
    parameter int N_EXT = 4
) (
    input  logic [31:0]      evt_word,
    input  logic [N_EXT-1:0] ext_evt,
    output logic             evt_true
);
    import tef_pkg::*;

    logic [6:0] code;
    logic       base;

    always_comb begin
        code = evt_word[6:0];
        base = 1'b0;
        if (code == EVT_ALWAYS) begin
            base = 1'b1;
        end else begin
            for (int i = 0; i < N_EXT; i++) begin
                if (code == 7'(i)) base = ext_evt[i];
            end
        end
        evt_true = evt_word[EVT_INV_BIT] ? !base : base;
    end
endmodule

// File: rtl/tef_startstop.sv
module tef_startstop #(
    parameter int NCMP = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            valid,
    input  logic [NCMP-1:0] start_m,
    input  logic [NCMP-1:0] stop_m,
    output logic            ss_now,
    output logic            ss_q
);
    logic ss_d;

    always_comb begin
        ss_d = ss_q;
        if (valid) begin
            if (|stop_m)       ss_d = 1'b0;
            else if (|start_m) ss_d = 1'b1;
        end
        ss_now = ss_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ss_q <= 1'b0;
        else        ss_q <= ss_d;
    end

    AST_STOP_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        valid && (|stop_m) |=> !ss_q); // R6
    AST_START_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        valid && (|start_m) && !(|stop_m) |=> ss_q); // R6
    AST_SS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !valid |=> $stable(ss_q)); // R7
endmodule

// File: rtl/trace_filter.sv
module trace_filter #(
    parameter int NUM_PAIRS = 4,
    parameter int ADDR_W    = 32,
    parameter int N_EXT     = 4,
    localparam int NCMP     = 2 * NUM_PAIRS,
    localparam int SEL_W    = $clog2(NCMP + 3)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [SEL_W-1:0]  cfg_sel,
    input  logic [31:0]       cfg_wdata,
    input  logic              in_valid,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [N_EXT-1:0]  ext_evt,
    output logic              trace_en,
    output logic [3:0]        capability
);
    import tef_pkg::*;

    localparam logic [SEL_W-1:0] SEL_CTL = SEL_W'(NCMP);
    localparam logic [SEL_W-1:0] SEL_SS  = SEL_W'(NCMP + 1);
    localparam logic [SEL_W-1:0] SEL_EVT = SEL_W'(NCMP + 2);

    typedef struct packed {
        logic [NCMP-1:0][ADDR_W-1:0] cmp;
        logic [31:0]                 ctl;
        logic [31:0]                 ss;
        logic [31:0]                 evt;
        logic                        en;
    } regs_t;

    regs_t q, d;

    logic [NUM_PAIRS-1:0] pair_hit;
    logic [NCMP-1:0]      start_m, stop_m;
    logic                 sel_hit, any_sel, range_ok;
    logic                 evt_true, ss_now, ss_q;

    // Ranges from comparator pairs
    for (genvar k = 0; k < NUM_PAIRS; k++) begin : g_pair
        tef_range_unit #(.ADDR_W(ADDR_W)) i_rng (
            .addr (in_addr),
            .lo   (q.cmp[2*k]),
            .hi   (q.cmp[2*k+1]),
            .hit  (pair_hit[k])
        );
    end

    // Exact-address start/stop matches
    for (genvar n = 0; n < NCMP; n++) begin : g_ss
        if (n < SS_MAX_CMP) begin : g_on
            assign start_m[n] = q.ss[n] && (in_addr == q.cmp[n]);
            assign stop_m[n]  = q.ss[n + SS_STOP_OFS] && (in_addr == q.cmp[n]);
        end else begin : g_off
            assign start_m[n] = 1'b0;
            assign stop_m[n]  = 1'b0;
        end
    end

    tef_startstop #(.NCMP(NCMP)) i_ss (
        .clk     (clk),
        .rst_n   (rst_n),
        .valid   (in_valid),
        .start_m (start_m),
        .stop_m  (stop_m),
        .ss_now  (ss_now),
        .ss_q    (ss_q)
    );

    tef_event_decode #(.N_EXT(N_EXT)) i_evt (
        .evt_word (q.evt),
        .ext_evt  (ext_evt),
        .evt_true (evt_true)
    );

    always_comb begin
        sel_hit  = |(pair_hit & q.ctl[NUM_PAIRS-1:0]);
        any_sel  = |q.ctl[NUM_PAIRS-1:0];
        range_ok = q.ctl[CTL_EXCL_BIT] ? !sel_hit : (!any_sel || sel_hit);

        d = q;
        if (cfg_we) begin
            for (int i = 0; i < NCMP; i++) begin
                if (cfg_sel == SEL_W'(i)) d.cmp[i] = cfg_wdata[ADDR_W-1:0];
            end
            if (cfg_sel == SEL_CTL) d.ctl = cfg_wdata;
            if (cfg_sel == SEL_SS)  d.ss  = cfg_wdata;
            if (cfg_sel == SEL_EVT) d.evt = cfg_wdata;
        end
        d.en = in_valid && evt_true && range_ok &&
               (!q.ctl[CTL_SS_BIT] || ss_now);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.cmp <= '0;
            q.ctl <= CTL_RESET;
            q.ss  <= '0;
            q.evt <= EVT_RESET;
            q.en  <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign trace_en   = q.en;
    assign capability = 4'(NUM_PAIRS);

    AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !trace_en); // R9
    AST_EVT_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && !evt_true |=> !trace_en); // R8
    AST_EXCL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && q.ctl[CTL_EXCL_BIT] && sel_hit |=> !trace_en); // R5
    AST_SS_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && q.ctl[CTL_SS_BIT] && !ss_now |=> !trace_en); // R6
endmodule

// File: tb/test_trace_filter.sv
module test_trace_filter;
    localparam int NP = 4;
    localparam int AW = 16;
    localparam int NE = 4;
    localparam int NC = 2 * NP;
    localparam int SW = $clog2(NC + 3);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [SW-1:0] cfg_sel = '0;
    logic [31:0]   cfg_wdata = '0;
    logic          in_valid = 1'b0;
    logic [AW-1:0] in_addr = '0;
    logic [NE-1:0] ext_evt = '0;
    logic          trace_en;
    logic [3:0]    capability;

    trace_filter #(.NUM_PAIRS(NP), .ADDR_W(AW), .N_EXT(NE)) i_trace_filter (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .in_valid(in_valid), .in_addr(in_addr),
        .ext_evt(ext_evt), .trace_en(trace_en), .capability(capability)
    );

    always #4 clk = ~clk;

    int n_cmp = 0;
    int n_bad = 0;

    logic [AW-1:0] m_cmp [NC];
    logic [31:0]   m_ctl, m_ss, m_evt;
    logic          m_state;

    task automatic chk(input string req, input logic act, input logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: trace_en=%0b expected %0b (addr=%h ctl=%h ss=%h evt=%h)",
                     req, act, exp, in_addr, m_ctl, m_ss, m_evt);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        cfg_we = 1'b0;
        in_valid = 1'b0;
        repeat (2) @(posedge clk);
        #1;
        rst_n = 1'b1;
        for (int i = 0; i < NC; i++) m_cmp[i] = '0;
        m_ctl = 32'h0100_0000;
        m_ss = '0;
        m_evt = 32'h6F;
        m_state = 1'b0;
    endtask

    task automatic wr(input int sel, input logic [31:0] data);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_sel = SW'(sel);
        cfg_wdata = data;
        in_valid = 1'b0;
        if (sel < NC) m_cmp[sel] = data[AW-1:0];
        else if (sel == NC) m_ctl = data;
        else if (sel == NC + 1) m_ss = data;
        else m_evt = data;
        @(posedge clk);
        #1;
        cfg_we = 1'b0;
    endtask

    task automatic issue(input logic v, input logic [AW-1:0] a,
                         input logic [NE-1:0] e, input string req);
        logic sel_hit, any_sel, rng, st, sp, nstate, b, exp;
        logic [6:0] code;
        @(negedge clk);
        in_valid = v;
        in_addr = a;
        ext_evt = e;
        sel_hit = 1'b0;
        any_sel = 1'b0;
        for (int k = 0; k < NP; k++) begin
            if (m_ctl[k]) begin
                any_sel = 1'b1;
                if (m_cmp[2*k] <= a && a < m_cmp[2*k+1]) sel_hit = 1'b1;
            end
        end
        rng = m_ctl[24] ? !sel_hit : (!any_sel || sel_hit);
        st = 1'b0;
        sp = 1'b0;
        for (int n = 0; n < NC; n++) begin
            if (a == m_cmp[n]) begin
                if (m_ss[n]) st = 1'b1;
                if (m_ss[n+16]) sp = 1'b1;
            end
        end
        nstate = !v ? m_state : (sp ? 1'b0 : (st ? 1'b1 : m_state));
        code = m_evt[6:0];
        if (code == 7'h6F) b = 1'b1;
        else if (int'(code) < NE) b = e[code[1:0]];
        else b = 1'b0;
        if (m_evt[14]) b = !b;
        exp = v && b && rng && (!m_ctl[25] || nstate);
        m_state = nstate;
        @(posedge clk);
        #1;
        chk(req, trace_en, exp);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #(8 * 200000);
        n_bad++;
        $display("FAIL watchdog: run did not finish");
        summary();
    end

    initial begin
        do_reset();
        @(negedge clk);
        chk("R1 reset output", trace_en, 1'b0);
        n_cmp++;
        if (capability !== 4'(NP)) begin
            n_bad++;
            $display("FAIL R2: capability=%0d expected %0d", capability, NP);
        end
        issue(1'b1, 16'h1234, '0, "R1 defaults trace all");
        issue(1'b0, 16'h1234, '0, "R9 idle cycle");

        // Ranges: [10,18) [20,30) [28,38) overlap, [40,40) empty
        wr(0, 32'h10); wr(1, 32'h18);
        wr(2, 32'h20); wr(3, 32'h30);
        wr(4, 32'h28); wr(5, 32'h38);
        wr(6, 32'h40); wr(7, 32'h40);

        for (int mask = 0; mask < 16; mask++) begin
            wr(NC, 32'(mask));
            for (int a = 0; a < 8'h50; a++) issue(1'b1, AW'(a), '0, "R3 R4 include sweep");
        end
        for (int mask = 0; mask < 16; mask++) begin
            wr(NC, 32'h0100_0000 | 32'(mask));
            for (int a = 0; a < 8'h50; a++) issue(1'b1, AW'(a), '0, "R3 R5 exclude sweep");
        end

        // Event decoding
        wr(NC, 32'h0);
        begin
            logic [31:0] codes [8];
            codes = '{32'h6F, 32'h406F, 32'h0, 32'h1, 32'h3, 32'h4002, 32'h50, 32'h4050};
            for (int c = 0; c < 8; c++) begin
                wr(NC + 2, codes[c]);
                for (int e = 0; e < 16; e++) issue(1'b1, 16'h5, NE'(e), "R8 event sweep");
            end
        end
        wr(NC + 2, 32'h406F);
        issue(1'b1, 16'h5, '0, "R10 write used next cycle");
        wr(NC + 2, 32'h6F);
        issue(1'b1, 16'h5, '0, "R10 write used next cycle");

        // Start/stop: start at cmp0 (0x10), stop at cmp3 (0x30)
        wr(NC, 32'h0200_0000);
        wr(NC + 1, 32'h1 | (32'h1 << 19));
        issue(1'b1, 16'h05, '0, "R6 before start");
        issue(1'b1, 16'h10, '0, "R6 start address traced");
        issue(1'b0, 16'h30, '0, "R7 idle keeps state");
        issue(1'b1, 16'h22, '0, "R6 window open");
        issue(1'b1, 16'h30, '0, "R6 stop address not traced");
        issue(1'b1, 16'h31, '0, "R6 after stop");
        issue(1'b1, 16'h10, '0, "R6 restart");
        // cmp1 (0x18) both start and stop: stop wins
        wr(NC + 1, 32'h1 | 32'h2 | (32'h1 << 17));
        issue(1'b1, 16'h18, '0, "R6 stop wins");
        issue(1'b1, 16'h11, '0, "R6 closed after tie");
        issue(1'b1, 16'h10, '0, "R6 reopen");
        wr(NC, 32'h0);
        issue(1'b1, 16'h30, '0, "R7 state ignored when disabled");
        issue(1'b1, 16'h18, '0, "R7 state ignored when disabled");
        wr(NC, 32'h0200_0000);
        issue(1'b1, 16'h11, '0, "R7 state closed while disabled");

        // Sticky state after reset
        do_reset();
        wr(NC, 32'h0200_0000);
        issue(1'b1, 16'h22, '0, "R7 reset state inactive");
        issue(1'b1, 16'h0, '0, "R7 reset state inactive");

        summary();
    end
endmodule